// File: doc/BRIEF.md
# Parallel Flash Command Sequence Decoder

This block sits behind the write port of a parallel NOR-style flash controller and interprets the bus write cycles the host issues. Each write strobe arrives with an address and a data word. The decoder follows the multi-cycle unlock and command sequences and reports which mode the device is in: normal read, erase-suspend read, autoselect, security-region access or unlock-bypass. When a program sequence completes, it raises a one-cycle program request. That request carries the target address and data captured from the final write, and a flag marking whether the security region is the target.

The read path asks the block for sector-protect status while autoselect is active. A read address that falls on the protect-status offset of a sector returns the protect bit of that sector as a byte. The host can enter unlock-bypass mode to program a run of words with two writes each instead of four. While that mode is active, the decoder accepts only the bypass-program and bypass-exit sequences.

Top module: `flash_cmd_decoder`

## Requirements
- R1: After reset, mode_o is 0 (read), prog_req_o is 0 and qry_valid_o is 0.
- R2: A standard program is four writes: data AAh at the first unlock address, data 55h at the second unlock address, data A0h at the first unlock address, then any address and data. One cycle after the clock edge of the fourth write, prog_req_o is high for exactly one cycle, with prog_addr_o and prog_data_o equal to that write's address and data.
- R3: The unlock addresses depend on byte_mode_i. With byte_mode_i=0 they are 555h then 2AAh. With byte_mode_i=1 they are AAAh then 555h. The command cycle must use the first unlock address.
- R4: The unlock writes followed by data 20h put the block in unlock-bypass mode (mode_o = 3).
- R5: In unlock-bypass mode, a write of data A0h followed by a write of address and data issues a program request as in R2. This repeats with no further unlock writes.
- R6: In unlock-bypass mode, a first write with data other than A0h or 90h has no effect. The mode stays 3, no program request is issued, and the next A0h write still starts a bypass program.
- R7: In unlock-bypass mode, a write of 90h followed by a write of 00h returns the block to read mode. If the second write is not 00h, the exit is abandoned and the mode stays 3.
- R8: The unlock writes followed by data 90h enter autoselect (mode_o = 1). There, a write of data F0h at any address returns the block to its read mode, and every other write is ignored.
- R9: In autoselect, a read address whose low SEC_OFS_W bits equal 02h (byte_mode_i=0) or 04h (byte_mode_i=1) gives qry_valid_o=1 and qry_data_o = 01h if sect_prot_i[sector] is set, else 00h. The sector is given by the address bits above SEC_OFS_W. Any other read address or mode gives qry_valid_o=0 and qry_data_o=00h.
- R10: While erase_susp_i is high, the read mode is reported as erase-suspend read (mode_o = 4). Leaving autoselect under that condition returns mode_o to 4.
- R11: The unlock writes followed by data 88h enter the security region (mode_o = 2, sec_read_o = 1). Programs there carry prog_sec_o = 1. The unlock writes, then 90h, then 00h leave the region. If the fourth write is not 00h, the block stays in the region.
- R12: A write that does not match the next expected cycle of a sequence abandons the partial sequence and leaves the mode unchanged. The following write is decoded as the start of a new sequence.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en_i | input | 1 | Bus write strobe, one cycle per write |
| wr_addr_i | input | ADDR_W | Write address |
| wr_data_i | input | DQ_W | Write data; commands use the low byte |
| byte_mode_i | input | 1 | 1 selects byte addressing for unlock and query offsets |
| erase_susp_i | input | 1 | An erase is suspended |
| rd_addr_i | input | ADDR_W | Read address for protect-status queries |
| sect_prot_i | input | 2**(ADDR_W-SEC_OFS_W) | Protect bit per sector |
| mode_o | output | 3 | 0 read, 1 autoselect, 2 security, 3 unlock-bypass, 4 erase-suspend read |
| sec_read_o | output | 1 | Reads are directed to the security region |
| prog_req_o | output | 1 | One-cycle program request |
| prog_addr_o | output | ADDR_W | Program target address |
| prog_data_o | output | DQ_W | Program data |
| prog_sec_o | output | 1 | Program targets the security region |
| qry_valid_o | output | 1 | Read address hits a protect-status location |
| qry_data_o | output | 8 | Protect-status byte |

## Verification
The bench builds the decoder with ADDR_W=14, SEC_OFS_W=11 and DQ_W=16. That gives eight sectors, so the protect query is checked on a protected sector and an unprotected one, each picked by the upper address bits. A 14-bit address still reaches the byte-mode unlock address AAAh, so the bench covers both addressing modes. A 16-bit data word shows that the command bytes are taken from the low byte while the program request carries the full word.

// File: rtl/fcd_pkg.sv
// Shared constants and types for the flash command decoder.
// Assumes command codes travel in the low byte of the write data.
package fcd_pkg;

    localparam logic [7:0] CMD_UNLOCK_A = 8'hAA;
    localparam logic [7:0] CMD_UNLOCK_B = 8'h55;
    localparam logic [7:0] CMD_PROGRAM  = 8'hA0;
    localparam logic [7:0] CMD_BYPASS   = 8'h20;
    localparam logic [7:0] CMD_ASEL     = 8'h90;
    localparam logic [7:0] CMD_SECURE   = 8'h88;
    localparam logic [7:0] CMD_RESET    = 8'hF0;
    localparam logic [7:0] CMD_ZERO     = 8'h00;

    localparam logic [11:0] UL_A_WORD = 12'h555;
    localparam logic [11:0] UL_B_WORD = 12'h2AA;
    localparam logic [11:0] UL_A_BYTE = 12'hAAA;
    localparam logic [11:0] UL_B_BYTE = 12'h555;

    typedef enum logic [2:0] {
        MODE_READ      = 3'd0,
        MODE_AUTOSEL   = 3'd1,
        MODE_SECURE    = 3'd2,
        MODE_BYPASS    = 3'd3,
        MODE_SUSP_READ = 3'd4
    } mode_e;

    typedef enum logic [1:0] {
        BASE_NORMAL,
        BASE_AUTOSEL,
        BASE_SECURE,
        BASE_BYPASS
    } base_e;

    typedef enum logic [2:0] {
        SQ_IDLE,
        SQ_UL1,
        SQ_UL2,
        SQ_PGM,
        SQ_SXIT,
        SQ_BPGM,
        SQ_BXIT
    } seq_e;

    typedef struct packed {
        logic ul1;
        logic ul2;
        logic at_cmd_addr;
        logic pgm;
        logic byp;
        logic asel;
        logic sec;
        logic rst;
        logic zero;
    } cyc_t;

endpackage

// File: rtl/fcd_cycle_match.sv
// Classifies one write cycle: unlock steps and command codes.
// Purely combinational; assumes ADDR_W is at least 12 bits.
module fcd_cycle_match
    import fcd_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [7:0]        cmd_i,
    input  logic              byte_mode_i,
    output cyc_t              cyc_o
);

    localparam logic [ADDR_W-1:0] A_WORD = ADDR_W'(UL_A_WORD);
    localparam logic [ADDR_W-1:0] B_WORD = ADDR_W'(UL_B_WORD);
    localparam logic [ADDR_W-1:0] A_BYTE = ADDR_W'(UL_A_BYTE);
    localparam logic [ADDR_W-1:0] B_BYTE = ADDR_W'(UL_B_BYTE);

    logic [ADDR_W-1:0] first_addr;
    logic [ADDR_W-1:0] second_addr;

    // Pick the unlock addresses for the active addressing mode
    always_comb begin
        first_addr  = byte_mode_i ? A_BYTE : A_WORD;
        second_addr = byte_mode_i ? B_BYTE : B_WORD;
    end

    // Decode the cycle against each known pattern
    always_comb begin
        cyc_o.at_cmd_addr = (addr_i == first_addr);
        cyc_o.ul1  = (addr_i == first_addr)  && (cmd_i == CMD_UNLOCK_A);
        cyc_o.ul2  = (addr_i == second_addr) && (cmd_i == CMD_UNLOCK_B);
        cyc_o.pgm  = (cmd_i == CMD_PROGRAM);
        cyc_o.byp  = (cmd_i == CMD_BYPASS);
        cyc_o.asel = (cmd_i == CMD_ASEL);
        cyc_o.sec  = (cmd_i == CMD_SECURE);
        cyc_o.rst  = (cmd_i == CMD_RESET);
        cyc_o.zero = (cmd_i == CMD_ZERO);
    end

endmodule

// File: rtl/fcd_seq_ctrl.sv
// Sequence state machine: tracks the base mode and the position inside
// a multi-cycle command. Fires a program strobe on the data write of a
// program sequence. Assumes one write per wr_en_i pulse.
module fcd_seq_ctrl
    import fcd_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  wr_en_i,
    input  cyc_t  cyc_i,
    output base_e base_o,
    output logic  fire_o,
    output logic  fire_sec_o
);

    base_e base_q, base_n;
    seq_e  seq_q,  seq_n;

    // Next-state decode for each write cycle
    always_comb begin
        base_n = base_q;
        seq_n  = seq_q;
        fire_o = 1'b0;
        if (wr_en_i) begin
            case (base_q)
                BASE_AUTOSEL: begin
                    seq_n = SQ_IDLE;
                    if (cyc_i.rst) base_n = BASE_NORMAL;
                end
                BASE_BYPASS: begin
                    case (seq_q)
                        SQ_BPGM: begin
                            fire_o = 1'b1;
                            seq_n  = SQ_IDLE;
                        end
                        SQ_BXIT: begin
                            seq_n = SQ_IDLE;
                            if (cyc_i.zero) base_n = BASE_NORMAL;
                        end
                        default: begin
                            if (cyc_i.pgm)       seq_n = SQ_BPGM;
                            else if (cyc_i.asel) seq_n = SQ_BXIT;
                            else                 seq_n = SQ_IDLE;
                        end
                    endcase
                end
                default: begin
                    case (seq_q)
                        SQ_IDLE: seq_n = cyc_i.ul1 ? SQ_UL1 : SQ_IDLE;
                        SQ_UL1:  seq_n = cyc_i.ul2 ? SQ_UL2 : SQ_IDLE;
                        SQ_UL2: begin
                            seq_n = SQ_IDLE;
                            if (cyc_i.at_cmd_addr) begin
                                if (cyc_i.pgm) begin
                                    seq_n = SQ_PGM;
                                end else if (base_q == BASE_NORMAL) begin
                                    if (cyc_i.byp)       base_n = BASE_BYPASS;
                                    else if (cyc_i.asel) base_n = BASE_AUTOSEL;
                                    else if (cyc_i.sec)  base_n = BASE_SECURE;
                                end else if (cyc_i.asel) begin
                                    seq_n = SQ_SXIT;
                                end
                            end
                        end
                        SQ_PGM: begin
                            fire_o = 1'b1;
                            seq_n  = SQ_IDLE;
                        end
                        SQ_SXIT: begin
                            seq_n = SQ_IDLE;
                            if (cyc_i.zero) base_n = BASE_NORMAL;
                        end
                        default: seq_n = SQ_IDLE;
                    endcase
                end
            endcase
        end
    end

    // State registers with synchronous reset
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_q <= BASE_NORMAL;
            seq_q  <= SQ_IDLE;
        end else begin
            base_q <= base_n;
            seq_q  <= seq_n;
        end
    end

    assign base_o     = base_q;
    assign fire_sec_o = (base_q == BASE_SECURE);

endmodule

// File: rtl/fcd_prog_reg.sv
// Registers the program request with its address, data and region flag.
// Assumes fire_i is a single-cycle strobe aligned with the data write.
module fcd_prog_reg #(
    parameter int ADDR_W = 16,
    parameter int DQ_W   = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fire_i,
    input  logic              fire_sec_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DQ_W-1:0]   data_i,
    output logic              req_o,
    output logic [ADDR_W-1:0] addr_o,
    output logic [DQ_W-1:0]   data_o,
    output logic              sec_o
);

    // Capture the target on a fire strobe; the request lasts one cycle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            req_o  <= 1'b0;
            addr_o <= '0;
            data_o <= '0;
            sec_o  <= 1'b0;
        end else begin
            req_o <= fire_i;
            if (fire_i) begin
                addr_o <= addr_i;
                data_o <= data_i;
                sec_o  <= fire_sec_i;
            end
        end
    end

endmodule

// File: rtl/fcd_prot_query.sv
// Read path for sector-protect status while autoselect is active.
// Sector index is the address bits above SEC_OFS_W.
module fcd_prot_query #(
    parameter int ADDR_W    = 16,
    parameter int SEC_OFS_W = 12
) (
    input  logic                                   active_i,
    input  logic                                   byte_mode_i,
    input  logic [ADDR_W-1:0]                      rd_addr_i,
    input  logic [(1 << (ADDR_W-SEC_OFS_W))-1:0]   prot_i,
    output logic                                   valid_o,
    output logic [7:0]                             data_o
);

    localparam int SEC_IDX_W = ADDR_W - SEC_OFS_W;
    localparam int NUM_SEC   = 1 << SEC_IDX_W;
    localparam logic [SEC_OFS_W-1:0] OFS_WORD = SEC_OFS_W'(2);
    localparam logic [SEC_OFS_W-1:0] OFS_BYTE = SEC_OFS_W'(4);

    logic [NUM_SEC-1:0]   hit_vec;
    logic [SEC_IDX_W-1:0] sec_idx;
    logic                 prot_bit;
    logic                 ofs_hit;

    assign sec_idx = rd_addr_i[ADDR_W-1:SEC_OFS_W];

    // One-hot sector select gated with each protect bit
    for (genvar s = 0; s < NUM_SEC; s++) begin : g_sec
        assign hit_vec[s] = (sec_idx == SEC_IDX_W'(s)) & prot_i[s];
    end

    // Offset match and status byte formation
    always_comb begin
        prot_bit = |hit_vec;
        ofs_hit  = rd_addr_i[SEC_OFS_W-1:0] == (byte_mode_i ? OFS_BYTE : OFS_WORD);
        valid_o  = active_i && ofs_hit;
        data_o   = {7'b0, valid_o & prot_bit};
    end

endmodule

// File: rtl/flash_cmd_decoder.sv
// Top of the flash command sequence decoder. Joins the cycle classifier,
// the sequence controller, the program request register and the protect
// query path, and maps the internal base mode to the reported mode code.
module flash_cmd_decoder
    import fcd_pkg::*;
#(
    parameter int ADDR_W    = 16,
    parameter int SEC_OFS_W = 12,
    parameter int DQ_W      = 16
) (
    input  logic                                 clk,
    input  logic                                 rst_n,
    input  logic                                 wr_en_i,
    input  logic [ADDR_W-1:0]                    wr_addr_i,
    input  logic [DQ_W-1:0]                      wr_data_i,
    input  logic                                 byte_mode_i,
    input  logic                                 erase_susp_i,
    input  logic [ADDR_W-1:0]                    rd_addr_i,
    input  logic [(1 << (ADDR_W-SEC_OFS_W))-1:0] sect_prot_i,
    output logic [2:0]                           mode_o,
    output logic                                 sec_read_o,
    output logic                                 prog_req_o,
    output logic [ADDR_W-1:0]                    prog_addr_o,
    output logic [DQ_W-1:0]                      prog_data_o,
    output logic                                 prog_sec_o,
    output logic                                 qry_valid_o,
    output logic [7:0]                           qry_data_o
);

    cyc_t  cyc;
    base_e base;
    logic  fire;
    logic  fire_sec;

    fcd_cycle_match #(.ADDR_W(ADDR_W)) i_match (
        .addr_i      (wr_addr_i),
        .cmd_i       (wr_data_i[7:0]),
        .byte_mode_i (byte_mode_i),
        .cyc_o       (cyc)
    );

    fcd_seq_ctrl i_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en_i    (wr_en_i),
        .cyc_i      (cyc),
        .base_o     (base),
        .fire_o     (fire),
        .fire_sec_o (fire_sec)
    );

    fcd_prog_reg #(.ADDR_W(ADDR_W), .DQ_W(DQ_W)) i_prog (
        .clk        (clk),
        .rst_n      (rst_n),
        .fire_i     (fire),
        .fire_sec_i (fire_sec),
        .addr_i     (wr_addr_i),
        .data_i     (wr_data_i),
        .req_o      (prog_req_o),
        .addr_o     (prog_addr_o),
        .data_o     (prog_data_o),
        .sec_o      (prog_sec_o)
    );

    fcd_prot_query #(.ADDR_W(ADDR_W), .SEC_OFS_W(SEC_OFS_W)) i_query (
        .active_i    (base == BASE_AUTOSEL),
        .byte_mode_i (byte_mode_i),
        .rd_addr_i   (rd_addr_i),
        .prot_i      (sect_prot_i),
        .valid_o     (qry_valid_o),
        .data_o      (qry_data_o)
    );

    // Map the base mode to the reported mode code
    always_comb begin
        case (base)
            BASE_AUTOSEL: mode_o = MODE_AUTOSEL;
            BASE_SECURE:  mode_o = MODE_SECURE;
            BASE_BYPASS:  mode_o = MODE_BYPASS;
            default:      mode_o = erase_susp_i ? MODE_SUSP_READ : MODE_READ;
        endcase
        sec_read_o = (base == BASE_SECURE);
    end

endmodule

// File: rtl/fcd_checker.sv
// Property checker for the flash command decoder, bound to the top module.
// Observes ports only.
module fcd_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       wr_en,
    input logic [7:0] cmd_byte,
    input logic [2:0] mode,
    input logic       prog_req,
    input logic       qry_valid
);

    AST_RESET_QUIET: assert property (@(posedge clk) !rst_n |=> (!prog_req && mode == 3'd0)); // R1

    AST_PROG_SINGLE: assert property (@(posedge clk) disable iff (!rst_n) prog_req |=> !prog_req); // R2

    AST_PROG_AFTER_WRITE: assert property (@(posedge clk) disable iff (!rst_n) prog_req |-> $past(wr_en)); // R5

    AST_BYPASS_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 3'd3 && $past(mode) != 3'd3) |-> ($past(wr_en) && $past(cmd_byte) == 8'h20)); // R4

    AST_BYPASS_LEAVE_READ: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(mode) == 3'd3 && mode != 3'd3) |-> ($past(cmd_byte) == 8'h00 && (mode == 3'd0 || mode == 3'd4))); // R7

    AST_AUTOSEL_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 3'd1 && $past(mode) != 3'd1) |-> ($past(wr_en) && $past(cmd_byte) == 8'h90)); // R8

    AST_QRY_ONLY_AUTOSEL: assert property (@(posedge clk) disable iff (!rst_n) qry_valid |-> mode == 3'd1); // R9

    AST_SEC_EXIT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(mode) == 3'd2 && mode != 3'd2) |-> ($past(wr_en) && $past(cmd_byte) == 8'h00)); // R11

endmodule

bind flash_cmd_decoder fcd_checker i_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en_i),
    .cmd_byte  (wr_data_i[7:0]),
    .mode      (mode_o),
    .prog_req  (prog_req_o),
    .qry_valid (qry_valid_o)
);

// File: tb/test_flash_cmd_decoder.sv
// Scoreboard bench: the driver pushes expected program requests, a monitor
// pops and compares them as the decoder raises prog_req_o.
module test_flash_cmd_decoder;

    localparam int CLK_PERIOD = 10;
    localparam int AW  = 14;
    localparam int OFW = 11;
    localparam int DW  = 16;
    localparam int NS  = 1 << (AW - OFW);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_en = 1'b0;
    logic [AW-1:0] wr_addr = '0;
    logic [DW-1:0] wr_data = '0;
    logic          byte_mode = 1'b0;
    logic          susp = 1'b0;
    logic [AW-1:0] rd_addr = '0;
    logic [NS-1:0] prot = 8'b0000_0101;
    logic [2:0]    mode;
    logic          sec_read;
    logic          prog_req;
    logic [AW-1:0] prog_addr;
    logic [DW-1:0] prog_data;
    logic          prog_sec;
    logic          qry_valid;
    logic [7:0]    qry_data;

    int checks = 0;
    int errors = 0;
    logic [AW+DW:0] exp_q[$];
    string          tag_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    flash_cmd_decoder #(.ADDR_W(AW), .SEC_OFS_W(OFW), .DQ_W(DW)) i_flash_cmd_decoder (
        .clk(clk), .rst_n(rst_n), .wr_en_i(wr_en), .wr_addr_i(wr_addr),
        .wr_data_i(wr_data), .byte_mode_i(byte_mode), .erase_susp_i(susp),
        .rd_addr_i(rd_addr), .sect_prot_i(prot), .mode_o(mode),
        .sec_read_o(sec_read), .prog_req_o(prog_req), .prog_addr_o(prog_addr),
        .prog_data_o(prog_data), .prog_sec_o(prog_sec),
        .qry_valid_o(qry_valid), .qry_data_o(qry_data)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic expect_prog(input string tag, input logic sec,
                               input logic [AW-1:0] a, input logic [DW-1:0] d);
        exp_q.push_back({sec, a, d});
        tag_q.push_back(tag);
    endtask

    task automatic unlock(input logic bm);
        if (bm) begin wr(14'hAAA, 16'h00AA); wr(14'h555, 16'h0055); end
        else    begin wr(14'h555, 16'h00AA); wr(14'h2AA, 16'h0055); end
    endtask

    // Monitor: compare every program request with the scoreboard head
    always @(negedge clk) begin
        if (rst_n && prog_req) begin
            if (exp_q.size() == 0) begin
                checks++; errors++;
                $display("FAIL R6: unexpected program actual=%0h expected=none",
                         {prog_sec, prog_addr, prog_data});
            end else begin
                logic [AW+DW:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                chk(t, {11'b0, prog_sec, prog_addr, prog_data}, {11'b0, e});
            end
        end
    end

    // Watchdog
    initial begin
        repeat (200000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog: actual=timeout expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 mode in reset", 32'(mode), 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 mode", 32'(mode), 32'd0);
        chk("R1 prog_req", 32'(prog_req), 32'd0);
        chk("R1 qry_valid", 32'(qry_valid), 32'd0);

        // R2 standard program, word mode
        unlock(1'b0); wr(14'h555, 16'h00A0);
        expect_prog("R2 standard program", 1'b0, 14'h0100, 16'h1234);
        wr(14'h0100, 16'h1234);
        chk("R2 mode stays read", 32'(mode), 32'd0);
        @(negedge clk);
        chk("R2 request lasts one cycle", 32'(prog_req), 32'd0);

        // R12 broken unlock: wrong second data, then lone A0 and data
        wr(14'h555, 16'h00AA); wr(14'h2AA, 16'h0012);
        wr(14'h555, 16'h00A0); wr(14'h0200, 16'h5555);
        chk("R12 mode after abort", 32'(mode), 32'd0);
        // R12 wrong second address, then a full program works
        wr(14'h555, 16'h00AA); wr(14'h123, 16'h0055);
        unlock(1'b0); wr(14'h555, 16'h00A0);
        expect_prog("R12 program after abort", 1'b0, 14'h0300, 16'hBEEF);
        wr(14'h0300, 16'hBEEF);

        // R3 byte mode addresses; word addresses do not unlock there
        byte_mode = 1'b1;
        unlock(1'b0); wr(14'h555, 16'h00A0); wr(14'h0010, 16'h0001);
        unlock(1'b1); wr(14'hAAA, 16'h00A0);
        expect_prog("R3 byte-mode program", 1'b0, 14'h0011, 16'h00C3);
        wr(14'h0011, 16'h00C3);
        byte_mode = 1'b0;

        // R4 bypass entry
        unlock(1'b0); wr(14'h555, 16'h0020);
        chk("R4 bypass mode", 32'(mode), 32'd3);

        // R5 two bypass programs
        wr(14'h0000, 16'h00A0);
        expect_prog("R5 bypass program 1", 1'b0, 14'h0400, 16'hA5A5);
        wr(14'h0400, 16'hA5A5);
        wr(14'h0000, 16'h00A0);
        expect_prog("R5 bypass program 2", 1'b0, 14'h0401, 16'h5A5A);
        wr(14'h0401, 16'h5A5A);
        chk("R5 still bypass", 32'(mode), 32'd3);

        // R6 ignored writes in bypass
        wr(14'h555, 16'h00AA); wr(14'h2AA, 16'h0055);
        wr(14'h555, 16'h00F0); wr(14'h0500, 16'h0020);
        chk("R6 mode unchanged", 32'(mode), 32'd3);
        chk("R6 no request", 32'(prog_req), 32'd0);
        wr(14'h0000, 16'h00A0);
        expect_prog("R6 bypass program after ignored", 1'b0, 14'h0600, 16'h0F0F);
        wr(14'h0600, 16'h0F0F);

        // R7 abandoned exit then real exit
        wr(14'h0000, 16'h0090); wr(14'h0000, 16'h0055);
        chk("R7 abandoned exit", 32'(mode), 32'd3);
        wr(14'h0000, 16'h0090); wr(14'h0000, 16'h0000);
        chk("R7 exit to read", 32'(mode), 32'd0);

        // R8 autoselect and R9 query
        unlock(1'b0); wr(14'h555, 16'h0090);
        chk("R8 autoselect mode", 32'(mode), 32'd1);
        wr(14'h0700, 16'h00A0); wr(14'h0700, 16'h1111);
        chk("R8 other writes ignored", 32'(mode), 32'd1);
        rd_addr = {3'd2, 11'h002}; #1;
        chk("R9 protected sector valid", 32'(qry_valid), 32'd1);
        chk("R9 protected sector data", 32'(qry_data), 32'h01);
        rd_addr = {3'd1, 11'h002}; #1;
        chk("R9 unprotected sector data", 32'(qry_data), 32'h00);
        chk("R9 unprotected sector valid", 32'(qry_valid), 32'd1);
        rd_addr = {3'd2, 11'h003}; #1;
        chk("R9 wrong offset", 32'(qry_valid), 32'd0);
        byte_mode = 1'b1; rd_addr = {3'd0, 11'h004}; #1;
        chk("R9 byte offset data", 32'(qry_data), 32'h01);
        rd_addr = {3'd0, 11'h002}; #1;
        chk("R9 word offset in byte mode", 32'(qry_valid), 32'd0);
        byte_mode = 1'b0;
        wr(14'h0123, 16'h00F0);
        chk("R8 reset to read", 32'(mode), 32'd0);
        rd_addr = {3'd2, 11'h002}; #1;
        chk("R9 no query outside autoselect", 32'(qry_valid), 32'd0);

        // R10 erase-suspend read
        susp = 1'b1; #1;
        chk("R10 suspend read", 32'(mode), 32'd4);
        unlock(1'b0); wr(14'h555, 16'h0090);
        chk("R10 autoselect from suspend", 32'(mode), 32'd1);
        wr(14'h0000, 16'h00F0);
        chk("R10 back to suspend read", 32'(mode), 32'd4);
        susp = 1'b0; #1;

        // R11 security region
        unlock(1'b0); wr(14'h555, 16'h0088);
        chk("R11 security mode", 32'(mode), 32'd2);
        chk("R11 sec_read", 32'(sec_read), 32'd1);
        unlock(1'b0); wr(14'h555, 16'h00A0);
        expect_prog("R11 security program", 1'b1, 14'h0008, 16'h7777);
        wr(14'h0008, 16'h7777);
        unlock(1'b0); wr(14'h555, 16'h0090); wr(14'h0000, 16'h0012);
        chk("R11 bad exit stays", 32'(mode), 32'd2);
        unlock(1'b0); wr(14'h555, 16'h0090); wr(14'h0000, 16'h0000);
        chk("R11 exit to read", 32'(mode), 32'd0);
        chk("R11 sec_read cleared", 32'(sec_read), 32'd0);

        repeat (3) @(negedge clk);
        chk("R2 all expected programs seen", 32'(exp_q.size()), 32'd0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule